// File: doc/BRIEF.md
# DRAM maintenance command sequencer

This block turns maintenance requests into DRAM command issues for a downstream command scheduler. A request carries a two-bit operation code, a chip-select mask and a calibration-length option. The sequencer accepts refresh, self-refresh entry, self-refresh exit and ZQ calibration in long or short form. It expands each request into one or more DRAM commands and hands them off one at a time. It also holds the per-rank clock-enable state, which changes as a side effect of self-refresh commands.

Both the request side and the command side use valid/ready. A request is taken on a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low for as long as a request is in progress, so a requester that keeps its valid and fields steady is held off, and its request is accepted once, after the current one completes. On the command side `dcmd_valid_o` stays high, with the opcode and chip select held constant, until the scheduler raises `dcmd_ready_i`. The scheduler can apply back-pressure for any number of cycles.

Refresh gets no spacing from this block: a new request is accepted in the cycle that `done_o` reports the previous one. Software is responsible for keeping refreshes far enough apart. `rank_present_i` is a static configuration input that lists the ranks that exist.

Top module: `dms_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `dcmd_valid_o` and `sr_err_o` are 0, `req_ready_o` is 1 and every bit of `cke_o` is 1.
- R2: `req_ready_o` is 0 in every cycle while a request is in progress. A request held valid during that time is accepted exactly once, after the current request completes.
- R3: Once `dcmd_valid_o` is high it stays high, with `dcmd_op_o` and `dcmd_cs_o` unchanged, until a cycle with `dcmd_ready_i` high. Each DRAM command is transferred exactly once.
- R4: Request code 0 (refresh) issues one command with opcode 1 and the written chip-select mask. No hold-off follows it: `req_ready_o` is 1 again in the cycle `done_o` is high.
- R5: Request code 3 (ZQ calibration) issues one command with the written chip-select mask. The opcode is 4 (long) when `req_zq_short_i` is 0 and 5 (short) when it is 1.
- R6: Request code 1 (self-refresh entry) issues one command with opcode 2 for each rank set in the chip-select mask, lowest rank first, each with a one-hot chip select. If the mask is empty, no command is issued.
- R7: Request code 2 (self-refresh exit) ignores the chip-select field. It issues one command with opcode 3 to each rank set in `rank_present_i`, lowest first, each with a one-hot chip select.
- R8: Only the first self-refresh exit after reset is carried out. A later exit issues no command and leaves `cke_o` unchanged. It still raises `done_o` in the cycle after acceptance, and it sets `sr_err_o`, which stays at 1 until reset.
- R9: `done_o` is high for one cycle: the cycle after the last command transfer of a request, or the cycle after acceptance if the request issues no command. `busy_o` is 0 in that cycle.
- R10: `cke_o` changes only in the cycle after a self-refresh command transfer. An entry clears the bit of the addressed rank; an exit sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rank_present_i | input | NUM_RANKS | Static mask of ranks that exist |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (high when idle) |
| req_op_i | input | 2 | Request code: 0 refresh, 1 SR entry, 2 SR exit, 3 ZQ |
| req_cs_i | input | NUM_RANKS | Chip-select mask for the request |
| req_zq_short_i | input | 1 | ZQ length: 0 long, 1 short |
| dcmd_valid_o | output | 1 | DRAM command valid |
| dcmd_ready_i | input | 1 | Scheduler accepts the command |
| dcmd_op_o | output | 3 | DRAM opcode: 1 REF, 2 SRE, 3 SRX, 4 ZQ long, 5 ZQ short |
| dcmd_cs_o | output | NUM_RANKS | Chip selects for the command |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sr_err_o | output | 1 | Sticky flag for a rejected repeat self-refresh exit |
| cke_o | output | NUM_RANKS | Per-rank clock-enable state |

## Verification
Internal faults in this block show up at the ports within a few cycles. If the remaining-rank mask is corrupted, the next handoff carries the wrong one-hot chip select, or `done_o` arrives early or late after the final transfer. If the exit-used latch is wrong, a repeated exit produces `dcmd_valid_o` in the cycle after acceptance, where a correct design raises `done_o` and `sr_err_o` instead. A clock-enable fault appears on `cke_o` in the cycle after the transfer that caused it, so the clock-enable state is compared against the model at every cycle of every request.

// File: rtl/dms_pkg.sv
package dms_pkg;
  typedef enum logic [1:0] {
    REQ_REF = 2'd0,
    REQ_SRE = 2'd1,
    REQ_SRX = 2'd2,
    REQ_ZQ  = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    DC_NONE = 3'd0,
    DC_REF  = 3'd1,
    DC_SRE  = 3'd2,
    DC_SRX  = 3'd3,
    DC_ZQL  = 3'd4,
    DC_ZQS  = 3'd5
  } dram_op_e;
endpackage

// File: rtl/dms_decode.sv
module dms_decode
  import dms_pkg::*;
#(
  parameter int NR = 2
) (
  input  logic [1:0]    op_i,
  input  logic [NR-1:0] cs_i,
  input  logic          zq_short_i,
  input  logic [NR-1:0] present_i,
  input  logic          exit_used_i,
  output logic [2:0]    dram_op_o,
  output logic          sweep_o,
  output logic [NR-1:0] mask_o,
  output logic          exit_req_o,
  output logic          reject_o,
  output logic          empty_o
);
  always_comb begin
    dram_op_o  = DC_REF;
    sweep_o    = 1'b0;
    mask_o     = cs_i;
    exit_req_o = 1'b0;
    reject_o   = 1'b0;
    case (req_op_e'(op_i))
      REQ_ZQ:  dram_op_o = zq_short_i ? DC_ZQS : DC_ZQL;
      REQ_SRE: begin
        dram_op_o = DC_SRE;
        sweep_o   = 1'b1;
      end
      REQ_SRX: begin
        dram_op_o  = DC_SRX;
        sweep_o    = 1'b1;
        exit_req_o = 1'b1;
        reject_o   = exit_used_i;
        mask_o     = exit_used_i ? '0 : present_i;
      end
      default: dram_op_o = DC_REF;
    endcase
    empty_o = sweep_o && (mask_o == '0);
  end
endmodule

// File: rtl/dms_pick.sv
module dms_pick #(
  parameter int NR = 2
) (
  input  logic [NR-1:0] mask_i,
  output logic [NR-1:0] pick_o
);
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < NR; i++) begin
      pick_o[i] = mask_i[i] && !found;
      found     = found || mask_i[i];
    end
  end
endmodule

// File: rtl/dms_cke.sv
module dms_cke #(
  parameter int NR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  logic          set_i,
  input  logic [NR-1:0] sel_i,
  output logic [NR-1:0] cke_o
);
  logic [NR-1:0] cke_q;

  for (genvar r = 0; r < NR; r++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cke_q[r] <= 1'b1;
      else if (upd_i && sel_i[r])    cke_q[r] <= set_i;
    end
  end

  assign cke_o = cke_q;
endmodule

// File: rtl/dms_seq.sv
module dms_seq
  import dms_pkg::*;
#(
  parameter int NUM_RANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RANKS-1:0] rank_present_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [1:0]           req_op_i,
  input  logic [NUM_RANKS-1:0] req_cs_i,
  input  logic                 req_zq_short_i,
  output logic                 dcmd_valid_o,
  input  logic                 dcmd_ready_i,
  output logic [2:0]           dcmd_op_o,
  output logic [NUM_RANKS-1:0] dcmd_cs_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 sr_err_o,
  output logic [NUM_RANKS-1:0] cke_o
);
  localparam int NR = NUM_RANKS;

  logic          busy_q, done_q, used_q, err_q, sweep_q;
  logic [2:0]    op_q;
  logic [NR-1:0] mask_q;

  logic [2:0]    dec_op;
  logic          dec_sweep, dec_exit, dec_reject, dec_empty;
  logic [NR-1:0] dec_mask;
  logic [NR-1:0] pick;
  logic [NR-1:0] rest;
  logic          accept, xfer, last, sr_cmd;

  dms_decode #(.NR(NR)) u_dec (
    .op_i        (req_op_i),
    .cs_i        (req_cs_i),
    .zq_short_i  (req_zq_short_i),
    .present_i   (rank_present_i),
    .exit_used_i (used_q),
    .dram_op_o   (dec_op),
    .sweep_o     (dec_sweep),
    .mask_o      (dec_mask),
    .exit_req_o  (dec_exit),
    .reject_o    (dec_reject),
    .empty_o     (dec_empty)
  );

  dms_pick #(.NR(NR)) u_pick (
    .mask_i (mask_q),
    .pick_o (pick)
  );

  assign accept = req_valid_i && !busy_q;
  assign xfer   = busy_q && dcmd_ready_i;
  assign rest   = mask_q & ~pick;
  assign last   = !sweep_q || (rest == '0);
  assign sr_cmd = (op_q == DC_SRE) || (op_q == DC_SRX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      used_q  <= 1'b0;
      err_q   <= 1'b0;
      sweep_q <= 1'b0;
      op_q    <= DC_NONE;
      mask_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (dec_exit)   used_q <= 1'b1;
        if (dec_reject) err_q  <= 1'b1;
        if (dec_empty) begin
          done_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          op_q    <= dec_op;
          sweep_q <= dec_sweep;
          mask_q  <= dec_mask;
        end
      end
      if (xfer) begin
        mask_q <= rest;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  dms_cke #(.NR(NR)) u_cke (
    .clk   (clk),
    .rst_n (rst_n),
    .upd_i (xfer && sr_cmd),
    .set_i (op_q == DC_SRX),
    .sel_i (pick),
    .cke_o (cke_o)
  );

  assign req_ready_o  = !busy_q;
  assign dcmd_valid_o = busy_q;
  assign dcmd_op_o    = op_q;
  assign dcmd_cs_o    = sweep_q ? pick : mask_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign sr_err_o     = err_q;
endmodule

// File: rtl/dms_checker.sv
module dms_checker #(
  parameter int NR = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NR-1:0] rank_present_i,
  input logic          dcmd_valid_o,
  input logic          dcmd_ready_i,
  input logic [2:0]    dcmd_op_o,
  input logic [NR-1:0] dcmd_cs_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          sr_err_o,
  input logic [NR-1:0] cke_o
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dcmd_valid_o && !dcmd_ready_i |=> dcmd_valid_o && $stable(dcmd_op_o) && $stable(dcmd_cs_o)); // R3

  AST_SRE_ONE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    dcmd_valid_o && dcmd_op_o == 3'd2 |-> $countones(dcmd_cs_o) == 1); // R6

  AST_SRX_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    dcmd_valid_o && dcmd_op_o == 3'd3 |-> $countones(dcmd_cs_o) == 1 && (dcmd_cs_o & ~rank_present_i) == '0); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sr_err_o |=> sr_err_o); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9

  AST_CKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(dcmd_valid_o && dcmd_ready_i) |=> $stable(cke_o)); // R10
endmodule

bind dms_seq dms_checker #(.NR(NUM_RANKS)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rank_present_i (rank_present_i),
  .dcmd_valid_o   (dcmd_valid_o),
  .dcmd_ready_i   (dcmd_ready_i),
  .dcmd_op_o      (dcmd_op_o),
  .dcmd_cs_o      (dcmd_cs_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .sr_err_o       (sr_err_o),
  .cke_o          (cke_o)
);

// File: tb/test_dms_seq.sv
`timescale 1ns/1ps
module test_dms_seq;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] rank_present_i = '0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [1:0]    req_op_i = '0;
  logic [NR-1:0] req_cs_i = '0;
  logic          req_zq_short_i = 1'b0;
  logic          dcmd_valid_o;
  logic          dcmd_ready_i = 1'b0;
  logic [2:0]    dcmd_op_o;
  logic [NR-1:0] dcmd_cs_o;
  logic          busy_o, done_o, sr_err_o;
  logic [NR-1:0] cke_o;

  always #2.5 clk = ~clk;

  dms_seq #(.NUM_RANKS(NR)) i_dms_seq (.*);

  int n_chk = 0;
  int n_fail = 0;
  int pct = 100;

  logic [NR-1:0] m_cke = '1;
  bit            m_used = 0;
  bit            m_err = 0;
  logic [2:0]    e_op [NR];
  logic [NR-1:0] e_cs [NR];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'd0: return "R4";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R5";
    endcase
  endfunction

  // expected command list for one request; updates the exit bookkeeping
  function automatic int plan(input logic [1:0] op, input logic [NR-1:0] cs, input bit zq);
    int n = 0;
    case (op)
      2'd0: begin e_op[0] = 3'd1; e_cs[0] = cs; n = 1; end
      2'd3: begin e_op[0] = zq ? 3'd5 : 3'd4; e_cs[0] = cs; n = 1; end
      2'd1: for (int i = 0; i < NR; i++)
              if (cs[i]) begin e_op[n] = 3'd2; e_cs[n] = NR'(1) << i; n++; end
      default: begin
        if (m_used) m_err = 1;
        else begin
          m_used = 1;
          for (int i = 0; i < NR; i++)
            if (rank_present_i[i]) begin e_op[n] = 3'd3; e_cs[n] = NR'(1) << i; n++; end
        end
      end
    endcase
    return n;
  endfunction

  task automatic drive(input logic [1:0] op, input logic [NR-1:0] cs, input bit zq);
    req_valid_i = 1'b1;
    req_op_i = op;
    req_cs_i = cs;
    req_zq_short_i = zq;
  endtask

  task automatic wait_accept();
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    req_cs_i = $urandom;
  endtask

  task automatic collect(input int n, input string tag);
    bit hv = 0;
    logic [2:0] hop = '0;
    logic [NR-1:0] hcs = '0;
    int idx = 0;
    bit rdy;
    while (idx < n) begin
      chk("R10", "cke mid-request", cke_o, m_cke);
      chk("R9", "done early", done_o, 0);
      chk("R3", "valid while busy", dcmd_valid_o, 1);
      chk("R2", "ready while busy", req_ready_o, 0);
      if (hv) begin
        chk("R3", "op held", dcmd_op_o, hop);
        chk("R3", "cs held", dcmd_cs_o, hcs);
      end
      rdy = ($urandom % 100) < pct;
      dcmd_ready_i = rdy;
      if (rdy) begin
        chk(tag, "opcode", dcmd_op_o, e_op[idx]);
        chk(tag, "chip select", dcmd_cs_o, e_cs[idx]);
        if (e_op[idx] == 3'd2) m_cke = m_cke & ~e_cs[idx];
        if (e_op[idx] == 3'd3) m_cke = m_cke | e_cs[idx];
        idx++;
        hv = 0;
      end else begin
        hv = 1;
        hop = dcmd_op_o;
        hcs = dcmd_cs_o;
      end
      @(negedge clk);
      dcmd_ready_i = 1'b0;
    end
    chk("R9", "done pulse", done_o, 1);
    chk("R9", "busy at done", busy_o, 0);
    chk("R4", "ready at done", req_ready_o, 1);
    chk("R3", "no extra command", dcmd_valid_o, 0);
    chk("R10", "cke after request", cke_o, m_cke);
    chk("R8", "error flag", sr_err_o, m_err);
  endtask

  task automatic run(input logic [1:0] op, input logic [NR-1:0] cs, input bit zq);
    int n;
    drive(op, cs, zq);
    wait_accept();
    n = plan(op, cs, zq);
    collect(n, tag_of(op));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog: actual=%0h expected=%0h", 1, 0);
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0BAD));
    rank_present_i = 4'b1011;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "dcmd_valid", dcmd_valid_o, 0);
    chk("R1", "err", sr_err_o, 0);
    chk("R1", "req_ready", req_ready_o, 1);
    chk("R1", "cke", cke_o, 4'hF);
    @(negedge clk);

    pct = 40;
    run(2'd1, 4'b1111, 0);           // R6: four entries, all cke cleared
    chk("R6", "all ranks down", cke_o, 4'h0);
    pct = 100;
    run(2'd0, 4'b0011, 0);           // R4
    run(2'd0, 4'b0100, 0);           // R4 back-to-back
    pct = 50;
    run(2'd3, 4'b1111, 0);           // R5 long
    run(2'd3, 4'b0010, 1);           // R5 short
    run(2'd1, 4'b0000, 0);           // R6 empty mask

    // R2/R7: exit sweeps present ranks while a refresh waits behind it
    begin
      int n;
      drive(2'd2, 4'b0100, 0);
      wait_accept();
      n = plan(2'd2, 4'b0100, 0);
      drive(2'd0, 4'b1001, 0);
      collect(n, "R7");
      chk("R7", "present ranks up", cke_o, 4'b1011);
      wait_accept();
      n = plan(2'd0, 4'b1001, 0);
      collect(n, "R2");
      repeat (3) begin
        @(negedge clk);
        chk("R2", "held request issued once", dcmd_valid_o, 0);
      end
    end

    run(2'd1, 4'b0010, 0);           // R6 single rank
    run(2'd2, 4'b1111, 0);           // R8 repeat exit rejected
    chk("R8", "cke kept after rejected exit", cke_o, 4'b1001);
    chk("R8", "err sticky", sr_err_o, 1);

    for (int k = 0; k < 80; k++) begin
      pct = 30 + ($urandom % 71);
      run(2'($urandom % 4), NR'($urandom), 1'($urandom % 2));
    end

    report();
    $finish;
  end
endmodule